// File: doc/BRIEF.md
# Pulse-Width Coded Byte Writer

This block transmits a single byte to a low-frequency tag by keying a coil-control line. Each data bit is sent as a pair of intervals. First the line is driven low, which shorts the coil. Then the line is driven high, which opens the coil. A one and a zero have the same overall bit time. They differ only in where the low-to-high edge falls inside that time.

Interval lengths are measured in ticks of a 1 µs enable input, not in raw clock cycles, so the same block works at any system clock frequency. A single start strobe captures the data byte. The block then plays out all eight bits, least significant first. It signals the end of the byte with a one-cycle done pulse. Carrier generation, checksums and multi-byte command sequencing are handled elsewhere.

Top module: `pwcw_writer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, coil_o is 1, busy_o is 0 and done_o is 0.
- R2: A start_i sampled high while busy_o is 0 makes busy_o 1 and coil_o 0 on the next cycle. A tick arriving on that same edge is not counted.
- R3: A data bit of value 1 holds coil_o low for ONE_LOW_TICKS ticks (default 1000), then high for ONE_HIGH_TICKS ticks (default 1000).
- R4: A data bit of value 0 holds coil_o low for ZERO_LOW_TICKS ticks (default 300), then high for ZERO_HIGH_TICKS ticks (default 1700).
- R5: Each bit consists of exactly one low interval followed by one high interval, so a byte produces exactly DATA_W low/high pairs. coil_o changes only on an edge that samples tick_i high, or on the edge that accepts a start.
- R6: Bits are sent least significant first, from bit 0 through bit DATA_W-1.
- R7: An edge with tick_i low advances no interval: coil_o and busy_o keep their values.
- R8: coil_o is 1 whenever busy_o is 0, including right after the final high interval.
- R9: start_i has no effect while busy_o is 1. This includes the edge on which the final high interval ends. The byte in progress keeps its data and timing, and the block is idle on the following cycle.
- R10: done_o is high for exactly one cycle. It is raised on the edge that samples the last tick of the final high interval, and busy_o falls on that same edge.
- R11: data_i is captured when a start is accepted. Changes to data_i while busy_o is 1 do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timebase enable, once per microsecond |
| start_i | input | 1 | Start strobe; accepted only when idle |
| data_i | input | DATA_W | Byte to transmit, captured on an accepted start |
| coil_o | output | 1 | Coil control: 0 shorts the coil, 1 opens it |
| busy_o | output | 1 | High while a byte is being transmitted |
| done_o | output | 1 | One-cycle pulse when the final interval ends |

## Verification
Two events can land on the same edge: the end of the last high interval (a tick sampled while the final bit's high counter is exhausted) and a fresh start strobe. The bench provokes this collision on purpose. It predicts from its own interval table which tick closes the byte, then raises start_i with that tick. It judges the outcome by requiring a single done pulse, an idle and high coil on the following cycle, and a normal acceptance of the next start one cycle later. Random start pulses and data changes are also scattered through busy bytes, to show that neither event disturbs the intervals.

// File: rtl/pwcw_pkg.sv
package pwcw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } pwcw_phase_e;

  // Number of ticks of one half of a bit cell.
  function automatic int unsigned interval_ticks(
    input logic        bit_val,
    input logic        high_half,
    input int unsigned one_lo,
    input int unsigned one_hi,
    input int unsigned zero_lo,
    input int unsigned zero_hi
  );
    if (bit_val) return high_half ? one_hi : one_lo;
    return high_half ? zero_hi : zero_lo;
  endfunction

  function automatic int unsigned max_of4(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c,
    input int unsigned d
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pwcw_bit_pick.sv
module pwcw_bit_pick #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);

  logic [DATA_W-1:0] sel_mask;

  // One-hot mask built from the bit position.
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sel_mask[g] = (idx_i == IDX_W'(g));
  end

  assign bit_o = |(word_i & sel_mask);

endmodule

// File: rtl/pwcw_tick_timer.sv
module pwcw_tick_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] remain_q;
  logic             at_zero;

  assign at_zero  = (remain_q == '0);
  assign expire_o = active_i && tick_i && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= load_val_i;
    end else if (active_i && tick_i && !at_zero) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/pwcw_seq.sv
module pwcw_seq
  import pwcw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              expire_i,
  output pwcw_phase_e       phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] word_o,
  output logic              accept_o,
  output logic              load_o,
  output logic              load_high_o,
  output logic              last_end_o,
  output logic              done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  pwcw_phase_e       phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] word_q;
  logic              done_q;
  logic              low_end;
  logic              high_end;
  logic              is_last;

  assign accept_o    = (phase_q == PH_IDLE) && start_i;
  assign low_end     = (phase_q == PH_LOW) && expire_i;
  assign high_end    = (phase_q == PH_HIGH) && expire_i;
  assign is_last     = (idx_q == LAST_IDX);
  assign last_end_o  = high_end && is_last;
  assign load_o      = accept_o || low_end || (high_end && !is_last);
  assign load_high_o = low_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_end_o;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_LOW;
            idx_q   <= '0;
            word_q  <= data_i;
          end
        end
        PH_LOW: begin
          if (expire_i) phase_q <= PH_HIGH;
        end
        PH_HIGH: begin
          if (expire_i) begin
            if (is_last) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_LOW;
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign word_o  = word_q;
  assign done_o  = done_q;

endmodule

// File: rtl/pwcw_writer.sv
module pwcw_writer
  import pwcw_pkg::*;
#(
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned ONE_LOW_TICKS   = 1000,
  parameter int unsigned ONE_HIGH_TICKS  = 1000,
  parameter int unsigned ZERO_LOW_TICKS  = 300,
  parameter int unsigned ZERO_HIGH_TICKS = 1700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              coil_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned MAX_LEN = max_of4(ONE_LOW_TICKS, ONE_HIGH_TICKS,
                                            ZERO_LOW_TICKS, ZERO_HIGH_TICKS);
  localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  pwcw_phase_e       phase;
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] held_word;
  logic              accept;
  logic              load;
  logic              load_high;
  logic              last_end;
  logic              phase_end;
  logic              is_idle;
  logic [DATA_W-1:0] pick_word;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_bit;
  logic [CNT_W-1:0]  load_val;

  assign is_idle = (phase == PH_IDLE);

  pwcw_seq #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .data_i      (data_i),
    .expire_i    (phase_end),
    .phase_o     (phase),
    .idx_o       (cur_idx),
    .word_o      (held_word),
    .accept_o    (accept),
    .load_o      (load),
    .load_high_o (load_high),
    .last_end_o  (last_end),
    .done_o      (done_o)
  );

  // Bit whose interval is loaded next: bit 0 of the incoming word on a
  // start, the current bit at a low end, the following bit at a high end.
  assign pick_word = is_idle ? data_i : held_word;
  assign pick_idx  = is_idle ? '0
                   : ((phase == PH_HIGH) ? IDX_W'(cur_idx + 1'b1) : cur_idx);

  pwcw_bit_pick #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_pick (
    .word_i (pick_word),
    .idx_i  (pick_idx),
    .bit_o  (pick_bit)
  );

  assign load_val = CNT_W'(interval_ticks(pick_bit, load_high,
                                          ONE_LOW_TICKS, ONE_HIGH_TICKS,
                                          ZERO_LOW_TICKS, ZERO_HIGH_TICKS) - 1);

  pwcw_tick_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (!is_idle),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (phase_end)
  );

  assign coil_o = (phase != PH_LOW);
  assign busy_o = !is_idle;

endmodule

// File: rtl/pwcw_writer_chk.sv
module pwcw_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic coil_o,
  input logic busy_o,
  input logic done_o,
  input logic accept,
  input logic phase_end,
  input logic last_end
);

  // R8
  idle_coil_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> coil_o);

  // R2
  start_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !coil_o));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(coil_o) && busy_o));

  // R9
  busy_start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last_end) |=> busy_o);

  // R9
  final_edge_start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_end && start_i) |=> (!busy_o && coil_o));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_with_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R5
  coil_rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coil_o) |-> $past(tick_i && phase_end));

  // R5
  coil_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(coil_o) |-> $past(accept || (busy_o && tick_i)));

endmodule

bind pwcw_writer pwcw_writer_chk u_pwcw_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .start_i   (start_i),
  .coil_o    (coil_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .accept    (accept),
  .phase_end (phase_end),
  .last_end  (last_end)
);

// File: tb/pwcw_writer_bench.sv
`timescale 1ns/1ps
module pwcw_writer_bench;

  localparam int DW = 8;
  localparam int OL = 10;
  localparam int OH = 10;
  localparam int ZL = 3;
  localparam int ZH = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] data = '0;
  logic          coil, busy, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwcw_writer #(
    .DATA_W          (DW),
    .ONE_LOW_TICKS   (OL),
    .ONE_HIGH_TICKS  (OH),
    .ZERO_LOW_TICKS  (ZL),
    .ZERO_HIGH_TICKS (ZH)
  ) u_pwcw_writer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .start_i (start),
    .data_i  (data),
    .coil_o  (coil),
    .busy_o  (busy),
    .done_o  (done)
  );

  function automatic int exp_len(input bit b, input bit high_half);
    if (high_half) return b ? OH : ZH;
    return b ? OL : ZL;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [DW-1:0] val, input int tick_pct,
                           input bit noise, input bit final_start);
    int lo [DW];
    int hi [DW];
    int bitn;
    int acc;
    int guard;
    bit prev_coil;
    bit tk;
    bit last_tk;
    bit seen_done;
    logic [DW-1:0] got;
    for (int i = 0; i < DW; i++) begin
      lo[i] = -1;
      hi[i] = -1;
    end
    @(negedge clk);
    start = 1'b1;
    data  = val;
    tick  = 1'($urandom_range(0, 1));
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && coil === 1'b0, "R2", "busy,coil after start",
          int'({busy, coil}), 2);
    prev_coil = 1'b0;
    bitn = 0;
    acc = 0;
    guard = 0;
    last_tk = 1'b1;
    seen_done = 1'b0;
    while (!seen_done && guard < 20000) begin
      if (done === 1'b1) begin
        if (bitn < DW) hi[bitn] = acc;
        bitn++;
        seen_done = 1'b1;
        check(busy === 1'b0 && coil === 1'b1, "R10", "busy,coil with done",
              int'({busy, coil}), 1);
        tick  = 1'b0;
        start = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R10", "done second cycle", int'(done), 0);
        check(busy === 1'b0 && coil === 1'b1, "R8", "idle busy,coil after byte",
              int'({busy, coil}), 1);
        if (final_start)
          check(busy === 1'b0, "R9", "start on final edge ignored", int'(busy), 0);
      end else begin
        if (coil !== prev_coil) begin
          if (!last_tk)
            check(1'b0, "R7", "coil moved without tick", int'(coil), int'(prev_coil));
          if (coil === 1'b1) begin
            if (bitn < DW) lo[bitn] = acc;
          end else begin
            if (bitn < DW) hi[bitn] = acc;
            bitn++;
          end
          acc = 0;
          prev_coil = coil;
        end else if (!last_tk) begin
          check(busy === 1'b1, "R7", "busy held without tick", int'(busy), 1);
        end
        tk = ($urandom_range(0, 99) < tick_pct);
        tick = tk;
        if (tk) acc++;
        start = 1'b0;
        if (noise) begin
          if ($urandom_range(0, 7) == 0) begin
            start = 1'b1;
            data  = DW'($urandom);
          end else if ($urandom_range(0, 4) == 0) begin
            data = DW'($urandom);
          end
        end
        if (final_start && coil && bitn == DW - 1 && tk &&
            acc == exp_len(val[DW-1], 1'b1)) begin
          start = 1'b1;
          data  = ~val;
        end
        last_tk = tk;
        @(negedge clk);
        guard++;
      end
    end
    tick  = 1'b0;
    start = 1'b0;
    check(bitn == DW, "R5", "low/high pairs per byte", bitn, DW);
    got = '0;
    for (int i = 0; i < DW; i++) begin
      check(lo[i] == exp_len(val[i], 1'b0), val[i] ? "R3" : "R4",
            $sformatf("low ticks bit %0d", i), lo[i], exp_len(val[i], 1'b0));
      check(hi[i] == exp_len(val[i], 1'b1), val[i] ? "R3" : "R4",
            $sformatf("high ticks bit %0d", i), hi[i], exp_len(val[i], 1'b1));
      got[i] = (lo[i] == OL);
    end
    check(got == val, "R6", "byte decoded lsb first", int'(got), int'(val));
    if (noise) check(got == val, "R11", "data held through busy", int'(got), int'(val));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(coil === 1'b1 && busy === 1'b0 && done === 1'b0, "R1",
          "coil,busy,done in reset", int'({coil, busy, done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(coil === 1'b1 && busy === 1'b0 && done === 1'b0, "R1",
          "coil,busy,done after reset", int'({coil, busy, done}), 4);

    // Directed patterns
    send_byte(8'hA5, 100, 1'b0, 1'b0);
    send_byte(8'h00, 100, 1'b0, 1'b0);
    send_byte(8'hFF, 30, 1'b0, 1'b0);
    send_byte(8'h01, 50, 1'b0, 1'b0);
    send_byte(8'h80, 50, 1'b1, 1'b0);
    // Start collides with the final interval end
    send_byte(8'h3C, 60, 1'b0, 1'b1);
    send_byte(8'hC3, 100, 1'b0, 1'b1);

    // Constrained random bytes
    for (int n = 0; n < 25; n++) begin
      send_byte(DW'($urandom), int'($urandom_range(20, 100)), 1'b1,
                ($urandom_range(0, 2) == 0));
    end

    // Idle with ticks: coil stays high, busy stays low
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      tick = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    tick = 1'b0;
    check(busy === 1'b0 && coil === 1'b1, "R8", "idle with ticks",
          int'({busy, coil}), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule